// File: doc/BRIEF.md
# Rename History Buffer with Rollback

This block keeps an ordered log of destination-register renames for one thread of an out-of-order core. Every time rename maps an architectural register to a freshly allocated physical register, the block logs the instruction's sequence number, the architectural register, the new physical register and the physical register that the mapping replaced. The log can then be unwound in either direction. A squash unwinds it from the youngest end and writes the replaced mappings back into the map table. A commit drains it from the oldest end and gives the superseded physical registers back to the free list.

Map table, free list and scoreboard live outside the block. The block drives one write port to each of them. A walk, in either direction, handles at most one entry per cycle and holds `busy_o` high until it is done. New renames are refused while a squash walk runs and while the log is full. Sequence numbers are compared as plain unsigned values. A squash or commit number does not have to match any logged entry, because instructions without a destination register never add one.

Top module: `rename_history_buf`

## Requirements
- R1: After reset the log is empty (`empty_o`=1, `full_o`=0), `busy_o` is 0 and `ins_ready_o` is 1.
- R2: A rename presented on `ins_valid_i` while `ins_ready_o` is 1 is appended at the youngest end of the log, and `empty_o` falls.
- R3: A squash with number S removes entries youngest first for as long as the youngest entry's sequence number is greater than S. For each removed entry the block writes the map entry of its architectural register back to the replaced physical register and returns the new physical register to the free list. The map table then holds what it held before the squashed renames.
- R4: During a squash, a returned physical register whose index is at or above `SB_BASE` (the combined count of integer and floating-point physical registers) also gets a scoreboard ready write. Lower indices get none.
- R5: A commit with number C removes entries oldest first for as long as the oldest entry's sequence number is at or below C. For each removed entry the replaced physical register is freed, and no map write occurs.
- R6: A commit is ignored when the log is empty or when its oldest entry is younger than C. A squash on an empty log produces no writes.
- R7: A commit is ignored when `cm_squash_i` is set, when a squash is requested in the same cycle, or while a squash walk is in progress.
- R8: Each walk removes at most one entry per cycle. `busy_o` is high from the cycle after the request until one cycle after the last removal.
- R9: While a squash walk is in progress `ins_ready_o` is 0, and renames presented during the walk are not logged.
- R10: With `DEPTH` entries logged, `full_o` is 1 and `ins_ready_o` is 0, and a further rename is not logged.
- R11: Squash and commit numbers that fall in gaps between logged sequence numbers are handled by comparison alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ins_valid_i | input | 1 | Rename to be logged |
| ins_seq_i | input | SEQ_W | Sequence number of the rename |
| ins_arch_i | input | ARCH_W | Architectural destination register |
| ins_new_i | input | PHYS_W | Newly allocated physical register |
| ins_prev_i | input | PHYS_W | Physical register previously mapped |
| ins_ready_o | output | 1 | Log can accept a rename |
| sq_valid_i | input | 1 | Squash request |
| sq_seq_i | input | SEQ_W | Youngest surviving sequence number |
| cm_valid_i | input | 1 | Commit request |
| cm_seq_i | input | SEQ_W | Youngest committed sequence number |
| cm_squash_i | input | 1 | Commit stage is squashing this cycle |
| busy_o | output | 1 | A walk is in progress |
| full_o | output | 1 | Log holds DEPTH entries |
| empty_o | output | 1 | Log holds no entries |
| map_we_o | output | 1 | Map table write enable |
| map_arch_o | output | ARCH_W | Map table write address |
| map_phys_o | output | PHYS_W | Map table write data |
| fl_we_o | output | 1 | Free list return enable |
| fl_phys_o | output | PHYS_W | Physical register returned |
| sb_we_o | output | 1 | Scoreboard ready set enable |
| sb_phys_o | output | PHYS_W | Physical register marked ready |

## Verification
The hardest case to reach is a squash that arrives against a full log while renames are still being pushed at the block. Every walk cycle has to refuse the rename, and the walk must leave the map table exactly as it was before the burst. The bench fills the log to `DEPTH`, holds `ins_valid_i` high through the entire squash walk and drops it on the first cycle `busy_o` reads low. It then compares its own model of the map table against a snapshot and counts the free-list returns, which must equal `DEPTH` and start with the youngest register. Same-cycle commit and squash requests and sequence numbers that fall in gaps are reached with directed sequences.

// File: rtl/rhb_pkg.sv
`timescale 1ns/1ps
package rhb_pkg;
  typedef enum logic [1:0] {
    WALK_IDLE   = 2'd0,
    WALK_SQUASH = 2'd1,
    WALK_COMMIT = 2'd2
  } walk_e;
endpackage

// File: rtl/rhb_store.sv
`timescale 1ns/1ps
module rhb_store #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] push_data_i,
  input  logic             pop_new_i,
  input  logic             pop_old_i,
  output logic [WIDTH-1:0] newest_o,
  output logic [WIDTH-1:0] oldest_o,
  output logic             full_o,
  output logic             empty_o
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [IDX_W-1:0] head_q, tail_q, newest_idx;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [IDX_W-1:0] nxt(input logic [IDX_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [IDX_W-1:0] prv(input logic [IDX_W-1:0] p);
    return (p == '0) ? LAST : p - 1'b1;
  endfunction

  assign newest_idx = prv(tail_q);
  assign newest_o   = mem_q[newest_idx];
  assign oldest_o   = mem_q[head_q];
  assign full_o     = (cnt_q == FULL_CNT);
  assign empty_o    = (cnt_q == '0);

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[tail_q] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      // push and pop_new never coincide; push and pop_old may
      if (pop_new_i)      tail_q <= newest_idx;
      else if (push_i)    tail_q <= nxt(tail_q);
      if (pop_old_i)      head_q <= nxt(head_q);
      if (push_i && !(pop_new_i || pop_old_i))      cnt_q <= cnt_q + 1'b1;
      else if (!push_i && (pop_new_i || pop_old_i)) cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/rhb_ctrl.sv
`timescale 1ns/1ps
module rhb_ctrl
  import rhb_pkg::*;
#(
  parameter int SEQ_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sq_valid_i,
  input  logic [SEQ_W-1:0] sq_seq_i,
  input  logic             cm_valid_i,
  input  logic [SEQ_W-1:0] cm_seq_i,
  input  logic             cm_squash_i,
  input  logic             empty_i,
  input  logic [SEQ_W-1:0] newest_seq_i,
  input  logic [SEQ_W-1:0] oldest_seq_i,
  output logic             pop_new_o,
  output logic             pop_old_o,
  output walk_e            state_o
);
  walk_e            state_q, state_d;
  logic [SEQ_W-1:0] tgt_q, tgt_d;
  logic             cm_ok;

  assign state_o = state_q;
  assign cm_ok   = cm_valid_i && !cm_squash_i && !sq_valid_i && (state_q != WALK_SQUASH);

  always_comb begin
    pop_new_o = !sq_valid_i && (state_q == WALK_SQUASH) && !empty_i && (newest_seq_i > tgt_q);
    pop_old_o = !sq_valid_i && (state_q == WALK_COMMIT) && !empty_i && (oldest_seq_i <= tgt_q);
    state_d   = state_q;
    tgt_d     = tgt_q;
    if (sq_valid_i) begin
      state_d = WALK_SQUASH;
      tgt_d   = sq_seq_i;
    end else begin
      unique case (state_q)
        WALK_IDLE: begin
          if (cm_ok && !empty_i && (oldest_seq_i <= cm_seq_i)) begin
            state_d = WALK_COMMIT;
            tgt_d   = cm_seq_i;
          end
        end
        WALK_SQUASH: begin
          if (!pop_new_o) state_d = WALK_IDLE;
        end
        WALK_COMMIT: begin
          if (cm_ok && (cm_seq_i > tgt_q)) tgt_d = cm_seq_i;
          else if (!pop_old_o)            state_d = WALK_IDLE;
        end
        default: state_d = WALK_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WALK_IDLE;
      tgt_q   <= '0;
    end else begin
      state_q <= state_d;
      tgt_q   <= tgt_d;
    end
  end
endmodule

// File: rtl/rhb_release.sv
`timescale 1ns/1ps
module rhb_release #(
  parameter int ARCH_W  = 5,
  parameter int PHYS_W  = 7,
  parameter int SB_BASE = 112
) (
  input  logic              pop_new_i,
  input  logic              pop_old_i,
  input  logic [ARCH_W-1:0] new_arch_i,
  input  logic [PHYS_W-1:0] new_phys_i,
  input  logic [PHYS_W-1:0] new_prev_i,
  input  logic [PHYS_W-1:0] old_prev_i,
  output logic              map_we_o,
  output logic [ARCH_W-1:0] map_arch_o,
  output logic [PHYS_W-1:0] map_phys_o,
  output logic              fl_we_o,
  output logic [PHYS_W-1:0] fl_phys_o,
  output logic              sb_we_o,
  output logic [PHYS_W-1:0] sb_phys_o
);
  localparam logic [PHYS_W-1:0] SB_LIM = PHYS_W'(SB_BASE);

  always_comb begin
    map_we_o   = pop_new_i;
    map_arch_o = new_arch_i;
    map_phys_o = new_prev_i;
    fl_we_o    = pop_new_i || pop_old_i;
    fl_phys_o  = pop_new_i ? new_phys_i : old_prev_i;
    sb_we_o    = pop_new_i && (new_phys_i >= SB_LIM);
    sb_phys_o  = new_phys_i;
  end
endmodule

// File: rtl/rename_history_buf.sv
`timescale 1ns/1ps
module rename_history_buf
  import rhb_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int SEQ_W   = 16,
  parameter int ARCH_W  = 5,
  parameter int PHYS_W  = 7,
  parameter int SB_BASE = 112
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ins_valid_i,
  input  logic [SEQ_W-1:0]  ins_seq_i,
  input  logic [ARCH_W-1:0] ins_arch_i,
  input  logic [PHYS_W-1:0] ins_new_i,
  input  logic [PHYS_W-1:0] ins_prev_i,
  output logic              ins_ready_o,
  input  logic              sq_valid_i,
  input  logic [SEQ_W-1:0]  sq_seq_i,
  input  logic              cm_valid_i,
  input  logic [SEQ_W-1:0]  cm_seq_i,
  input  logic              cm_squash_i,
  output logic              busy_o,
  output logic              full_o,
  output logic              empty_o,
  output logic              map_we_o,
  output logic [ARCH_W-1:0] map_arch_o,
  output logic [PHYS_W-1:0] map_phys_o,
  output logic              fl_we_o,
  output logic [PHYS_W-1:0] fl_phys_o,
  output logic              sb_we_o,
  output logic [PHYS_W-1:0] sb_phys_o
);
  localparam int ENT_W    = SEQ_W + ARCH_W + 2 * PHYS_W;
  localparam int NEW_LO   = PHYS_W;
  localparam int ARCH_LO  = 2 * PHYS_W;
  localparam int SEQ_LO   = 2 * PHYS_W + ARCH_W;

  logic [ENT_W-1:0] newest, oldest;
  logic             pop_new, pop_old, push, st_full, st_empty;
  walk_e            state;

  assign ins_ready_o = !st_full && (state != WALK_SQUASH);
  assign push        = ins_valid_i && ins_ready_o;
  assign busy_o      = (state != WALK_IDLE);
  assign full_o      = st_full;
  assign empty_o     = st_empty;

  rhb_store #(.DEPTH(DEPTH), .WIDTH(ENT_W)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push),
    .push_data_i ({ins_seq_i, ins_arch_i, ins_new_i, ins_prev_i}),
    .pop_new_i   (pop_new),
    .pop_old_i   (pop_old),
    .newest_o    (newest),
    .oldest_o    (oldest),
    .full_o      (st_full),
    .empty_o     (st_empty)
  );

  rhb_ctrl #(.SEQ_W(SEQ_W)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sq_valid_i   (sq_valid_i),
    .sq_seq_i     (sq_seq_i),
    .cm_valid_i   (cm_valid_i),
    .cm_seq_i     (cm_seq_i),
    .cm_squash_i  (cm_squash_i),
    .empty_i      (st_empty),
    .newest_seq_i (newest[ENT_W-1:SEQ_LO]),
    .oldest_seq_i (oldest[ENT_W-1:SEQ_LO]),
    .pop_new_o    (pop_new),
    .pop_old_o    (pop_old),
    .state_o      (state)
  );

  rhb_release #(.ARCH_W(ARCH_W), .PHYS_W(PHYS_W), .SB_BASE(SB_BASE)) u_rel (
    .pop_new_i  (pop_new),
    .pop_old_i  (pop_old),
    .new_arch_i (newest[SEQ_LO-1:ARCH_LO]),
    .new_phys_i (newest[ARCH_LO-1:NEW_LO]),
    .new_prev_i (newest[PHYS_W-1:0]),
    .old_prev_i (oldest[PHYS_W-1:0]),
    .map_we_o   (map_we_o),
    .map_arch_o (map_arch_o),
    .map_phys_o (map_phys_o),
    .fl_we_o    (fl_we_o),
    .fl_phys_o  (fl_phys_o),
    .sb_we_o    (sb_we_o),
    .sb_phys_o  (sb_phys_o)
  );
endmodule

// File: rtl/rhb_checker.sv
`timescale 1ns/1ps
module rhb_checker #(
  parameter int PHYS_W  = 7,
  parameter int SB_BASE = 112
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ins_ready_o,
  input logic              sq_valid_i,
  input logic              cm_valid_i,
  input logic              cm_squash_i,
  input logic              busy_o,
  input logic              full_o,
  input logic              empty_o,
  input logic              map_we_o,
  input logic              fl_we_o,
  input logic [PHYS_W-1:0] fl_phys_o,
  input logic              sb_we_o,
  input logic [PHYS_W-1:0] sb_phys_o
);
  AST_SB_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sb_we_o |-> (sb_phys_o >= PHYS_W'(SB_BASE))); // R4
  AST_SB_WITH_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sb_we_o |-> (fl_we_o && map_we_o && fl_phys_o == sb_phys_o)); // R4
  AST_WRITE_NEEDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_we_o |-> busy_o); // R8
  AST_NO_INS_IN_SQUASH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    map_we_o |-> !ins_ready_o); // R9
  AST_FULL_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> (!ins_ready_o && !empty_o)); // R10
  AST_EMPTY_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> !fl_we_o); // R6
  AST_CM_SKIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cm_valid_i && cm_squash_i && !sq_valid_i && !busy_o) |=> !fl_we_o); // R7
endmodule

bind rename_history_buf rhb_checker #(.PHYS_W(PHYS_W), .SB_BASE(SB_BASE)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ins_ready_o (ins_ready_o),
  .sq_valid_i  (sq_valid_i),
  .cm_valid_i  (cm_valid_i),
  .cm_squash_i (cm_squash_i),
  .busy_o      (busy_o),
  .full_o      (full_o),
  .empty_o     (empty_o),
  .map_we_o    (map_we_o),
  .fl_we_o     (fl_we_o),
  .fl_phys_o   (fl_phys_o),
  .sb_we_o     (sb_we_o),
  .sb_phys_o   (sb_phys_o)
);

// File: tb/sim_rename_history_buf.sv
`timescale 1ns/1ps
module sim_rename_history_buf;
  localparam int DEPTH = 8, SEQ_W = 16, ARCH_W = 5, PHYS_W = 7, SB_BASE = 112;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ins_valid = 0, sq_valid = 0, cm_valid = 0, cm_squash = 0;
  logic [SEQ_W-1:0] ins_seq = '0, sq_seq = '0, cm_seq = '0;
  logic [ARCH_W-1:0] ins_arch = '0;
  logic [PHYS_W-1:0] ins_new = '0, ins_prev = '0;
  logic ins_ready, busy, full, empty, map_we, fl_we, sb_we;
  logic [ARCH_W-1:0] map_arch;
  logic [PHYS_W-1:0] map_phys, fl_phys, sb_phys;

  always #2.5 clk = ~clk;

  rename_history_buf #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .ARCH_W(ARCH_W),
                       .PHYS_W(PHYS_W), .SB_BASE(SB_BASE)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .ins_valid_i(ins_valid), .ins_seq_i(ins_seq), .ins_arch_i(ins_arch),
    .ins_new_i(ins_new), .ins_prev_i(ins_prev), .ins_ready_o(ins_ready),
    .sq_valid_i(sq_valid), .sq_seq_i(sq_seq),
    .cm_valid_i(cm_valid), .cm_seq_i(cm_seq), .cm_squash_i(cm_squash),
    .busy_o(busy), .full_o(full), .empty_o(empty),
    .map_we_o(map_we), .map_arch_o(map_arch), .map_phys_o(map_phys),
    .fl_we_o(fl_we), .fl_phys_o(fl_phys), .sb_we_o(sb_we), .sb_phys_o(sb_phys)
  );

  int checks = 0, fails = 0, cycles = 0;
  int map_n = 0, fl_n = 0, sb_n = 0;
  int fl_log [64];
  int sb_log [64];
  int spec_map [32];
  int snap [32];

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d expected 0", cycles);
      finish_run();
    end
  end

  // bench model of the external tables
  always @(negedge clk) if (rst_n) begin
    if (map_we) begin spec_map[map_arch] = int'(map_phys); map_n++; end
    if (fl_we && fl_n < 64) begin fl_log[fl_n] = int'(fl_phys); fl_n++; end
    if (sb_we && sb_n < 64) begin sb_log[sb_n] = int'(sb_phys); sb_n++; end
  end

  task automatic clr_logs();
    map_n = 0; fl_n = 0; sb_n = 0;
  endtask

  task automatic take_snap();
    for (int i = 0; i < 32; i++) snap[i] = spec_map[i];
  endtask

  function automatic int snap_diff();
    int d = 0;
    for (int i = 0; i < 32; i++) if (snap[i] != spec_map[i]) d++;
    return d;
  endfunction

  task automatic do_ins(input int seq, input int arch, input int np);
    @(posedge clk); #1;
    ins_valid = 1; ins_seq = SEQ_W'(seq); ins_arch = ARCH_W'(arch);
    ins_new = PHYS_W'(np); ins_prev = PHYS_W'(spec_map[arch]);
    spec_map[arch] = np;
    @(posedge clk); #1;
    ins_valid = 0;
  endtask

  task automatic pulse(input bit sq, input int sseq, input bit cm, input int cseq, input bit csq);
    @(posedge clk); #1;
    sq_valid = sq; sq_seq = SEQ_W'(sseq);
    cm_valid = cm; cm_seq = SEQ_W'(cseq); cm_squash = csq;
    @(posedge clk); #1;
    sq_valid = 0; cm_valid = 0; cm_squash = 0;
  endtask

  // counts busy cycles after a request, returns when idle
  task automatic wait_idle(output int nbusy);
    nbusy = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (busy) nbusy++;
      else break;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 empty", int'(empty), 1);
    chk("R1 full", int'(full), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 ready", int'(ins_ready), 1);
  endtask

  task automatic t_squash_partial();
    int nb;
    do_ins(10, 3, 40); do_ins(11, 5, 41); do_ins(12, 3, 42);
    take_snap();
    do_ins(13, 3, 43); do_ins(15, 7, 44); do_ins(16, 5, 45);
    @(negedge clk);
    chk("R2 empty after insert", int'(empty), 0);
    clr_logs();
    pulse(1, 12, 0, 0, 0);
    wait_idle(nb);
    chk("R3 map writes", map_n, 3);
    chk("R3 map restored", snap_diff(), 0);
    chk("R3 free count", fl_n, 3);
    chk("R3 youngest first", fl_log[0], 45);
    chk("R11 gap skipped", fl_log[1], 44);
    chk("R3 third", fl_log[2], 43);
    chk("R8 busy cycles", nb, 4);
    chk("R4 no sb below base", sb_n, 0);
  endtask

  task automatic t_commit();
    int nb;
    clr_logs();
    pulse(0, 0, 1, 11, 0);
    wait_idle(nb);
    chk("R5 free count", fl_n, 2);
    chk("R5 oldest first", fl_log[0], 3);
    chk("R5 second", fl_log[1], 5);
    chk("R5 no map write", map_n, 0);
    chk("R8 commit busy", nb, 3);
  endtask

  task automatic t_commit_ignore();
    int nb;
    clr_logs();
    pulse(0, 0, 1, 5, 0);
    wait_idle(nb);
    chk("R6 older commit frees", fl_n, 0);
    chk("R6 older commit busy", nb, 0);
    chk("R6 entry kept", int'(empty), 0);
  endtask

  task automatic t_skip();
    int nb;
    clr_logs();
    pulse(0, 0, 1, 20, 1);
    wait_idle(nb);
    chk("R7 cm_squash frees", fl_n, 0);
    pulse(1, 20, 1, 20, 0);
    wait_idle(nb);
    chk("R7 same-cycle squash frees", fl_n, 0);
    chk("R7 entry kept", int'(empty), 0);
    pulse(0, 0, 1, 30, 0);
    wait_idle(nb);
    chk("R11 commit past gap count", fl_n, 1);
    chk("R5 prev freed", fl_log[0], 40);
    chk("R5 drained", int'(empty), 1);
  endtask

  task automatic t_squash_empty();
    int nb;
    clr_logs();
    pulse(1, 0, 0, 0, 0);
    wait_idle(nb);
    chk("R6 empty squash map", map_n, 0);
    chk("R6 empty squash free", fl_n, 0);
    pulse(0, 0, 1, 100, 0);
    wait_idle(nb);
    chk("R6 empty commit free", fl_n, 0);
  endtask

  task automatic t_sb();
    int nb;
    take_snap();
    do_ins(40, 9, 120); do_ins(41, 10, 50);
    clr_logs();
    pulse(1, 39, 0, 0, 0);
    wait_idle(nb);
    chk("R4 sb count", sb_n, 1);
    chk("R4 sb reg", sb_log[0], 120);
    chk("R3 map restored sb", snap_diff(), 0);
    chk("R3 free order sb", fl_log[0], 50);
  endtask

  task automatic t_full_hold();
    int ready_busy = 0;
    take_snap();
    for (int i = 0; i < DEPTH; i++) do_ins(50 + i, i, 60 + i);
    @(negedge clk);
    chk("R10 full", int'(full), 1);
    chk("R10 ready low", int'(ins_ready), 0);
    // rejected insert: not added to bench map model
    @(posedge clk); #1;
    ins_valid = 1; ins_seq = 16'd58; ins_arch = 5'd20; ins_new = 7'd99; ins_prev = 7'd20;
    @(posedge clk); #1;
    ins_seq = 16'd59; ins_arch = 5'd21; ins_new = 7'd98; ins_prev = 7'd21;
    clr_logs();
    sq_valid = 1; sq_seq = '0;
    @(posedge clk); #1;
    sq_valid = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (!busy) break;
      if (ins_ready) ready_busy++;
    end
    ins_valid = 0;
    repeat (3) @(negedge clk);
    chk("R9 ready during walk", ready_busy, 0);
    chk("R9 frees equal depth", fl_n, DEPTH);
    chk("R9 youngest first", fl_log[0], 60 + DEPTH - 1);
    chk("R10 map restored", snap_diff(), 0);
    chk("R9 empty after", int'(empty), 1);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) spec_map[i] = i;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_squash_partial();
    t_commit();
    t_commit_ignore();
    t_skip();
    t_squash_empty();
    t_sb();
    t_full_hold();
    finish_run();
  end
endmodule